// File: doc/BRIEF.md
# TDM Serial Audio Transmit Framer

This block is the transmit side of a serial audio port acting as clock master. It pulls parallel samples from a valid/ready stream and serialises them onto a data line. It also drives the bit clock and the frame clock. It does not divide any clock itself. An external divider supplies a strobe at twice the bit rate, and each strobe toggles the bit clock. The strobe that makes the selected edge is the launch point, where data and frame outputs advance by one bit.

A frame is two channel periods of `chan_len_m1 + 1` bit clocks each. When `odd_frame` is set, the second period is one bit clock longer. In level mode the frame clock is a 50 % left/right clock and the frame carries two slots: slot 0 in the first half and slot 1 in the second. In pulse mode the frame clock is a short sync pulse, and `slots_m1 + 1` slots of one container each follow back to back. In both modes the first slot begins `data_off` bit clocks after the frame edge. Each slot has a bit in `slot_mask`. An enabled slot takes one sample at its first bit, and a disabled slot is sent as zeros. All configuration is static while `tx_en` is high. Clearing `tx_en` parks the block, and the next enable starts a fresh frame.

The sequencer has four states:
- ST_IDLE: disabled.
- ST_LEAD: inside a frame, before a slot.
- ST_DATA: shifting a slot.
- ST_TAIL: after the last slot of a half or frame.

Transitions take place only at launch ticks:
- Any state goes to ST_IDLE when `tx_en` is low.
- ST_IDLE, ST_LEAD and ST_TAIL go to ST_DATA when a slot starts at the new position.
- ST_IDLE, ST_LEAD and ST_TAIL go to ST_LEAD when the position wraps to 0 and no slot starts there.
- ST_DATA goes to ST_DATA, starting a new slot, when a slot starts: the offset point, the second-half start in level mode, or the next TDM slot in pulse mode.
- ST_DATA goes to ST_LEAD on a frame wrap with no slot start.
- ST_DATA stays in ST_DATA while container bits remain.
- ST_DATA goes to ST_TAIL after the last container bit when no slot follows.

Top module: `serial_tx_framer`

## Requirements
- R1: While `tx_en` is high, each `bclk_en` strobe toggles `bclk`. The first strobe after enable makes a rising edge. While `tx_en` is low, `bclk` is 0.
- R2: `fall_launch`=0 makes `sdata` and `fclk` change only on strobes that raise `bclk`. `fall_launch`=1 makes them change only on strobes that lower it. The first launch after enable is frame position 0.
- R3: A frame lasts 2*(chan_len_m1+1)+odd_frame launches. In level mode (`pulse_mode`=0), `fclk` equals `left_high` for positions below chan_len_m1+1 and the inverse of `left_high` for the rest of the frame.
- R4: In pulse mode (`pulse_mode`=1), `fclk` is 1 for frame positions 0 to sync_len_m1 and 0 for the rest of the frame.
- R5: Slot placement, with C the container size. In level mode, slot 0 starts at position `data_off` and slot 1 starts at chan_len_m1+1+`data_off`; slot 0 is cut short where slot 1 starts. In pulse mode, slot k (k ≤ slots_m1) starts at `data_off` + k*C. A slot lasts C bits or until the frame ends. `sdata` is 0 outside slots.
- R6: `size_code` n (1..7) gives C = 4n+4 bits, and code 0 is treated as 8. The sample in the low C−`mask_bits` bits of `s_data` is placed above `mask_bits` zero bits inside the container.
- R7: `lsb_first`=0 sends container bit C−1 first. `lsb_first`=1 sends container bit 0 first.
- R8: A slot whose `slot_mask` bit is 0 is sent as zeros and takes no sample.
- R9: If an enabled slot starts while `s_valid` is 0, the slot is sent as zeros and `underflow` is 1 for exactly the next clock cycle.
- R10: While `tx_en` is low, `sdata`, `fclk`, `bclk`, `underflow` and `s_ready` are all 0 and no sample is taken. Reset gives the same state.
- R11: `s_ready` is 1 only in the clock cycle of a launch that starts an enabled slot. A sample transfers when `s_valid` and `s_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| bclk_en | input | 1 | Strobe at twice the bit rate from the external divider |
| pulse_mode | input | 1 | 0: level left/right clock, 1: sync pulse with TDM slots |
| left_high | input | 1 | Level mode: frame clock level during the first half |
| chan_len_m1 | input | CLEN_W | Bit clocks per channel period minus 1 |
| odd_frame | input | 1 | Adds one bit clock to the second half |
| data_off | input | OFF_W | Bit clocks from the frame edge to the first data bit |
| sync_len_m1 | input | SYNC_W | Sync pulse width minus 1 |
| size_code | input | 3 | Container size code |
| mask_bits | input | 3 | Zeroed low bits of the container |
| lsb_first | input | 1 | Bit order select |
| fall_launch | input | 1 | Launch edge select |
| slots_m1 | input | SLOT_W | Pulse mode: slots per frame minus 1 |
| slot_mask | input | 2**SLOT_W | Per-slot sample enable |
| s_valid | input | 1 | Sample stream valid |
| s_data | input | 32 | Sample stream data, right-justified |
| s_ready | output | 1 | Sample stream ready |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock or sync pulse |
| sdata | output | 1 | Serial data |
| underflow | output | 1 | One-cycle pulse when an enabled slot finds no sample |

## Verification
The bench sweeps the following against an arithmetic frame model:
- Offsets 0, 1 and 2. An off-by-one in the offset compare would shift every slot by one position, or lose slot 0 entirely when the offset is 0.
- Odd frames. A framer that ignored `odd_frame` would wrap one launch early, and `fclk` would slide against the model from the second frame on.
- Level-mode slots that are longer than a half, so slot 1 must cut slot 0 short. A framer that finished the first container first would place the second channel late.
- Pulse-mode frames with up to eight back-to-back slots, so a slot-counter error shows as an extra or missing slot.
- Every container code with and without masking, both bit orders and both launch edges, so a reversed bit pick or a wrong edge corrupts `sdata` at once.
- Stalled streams. A design that sent stale data, or raised `s_ready` on a disabled slot, would consume samples out of order.

// File: rtl/sai_tx_pkg.sv
package sai_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_DATA,
        ST_TAIL
    } seq_state_e;

    localparam int SAMPLE_W = 32;

    // container width in bits; code 0 falls back to the smallest size
    function automatic logic [5:0] slot_bits(input logic [2:0] code);
        return (code == 3'd0) ? 6'd8 : ({1'b0, code, 2'b00} + 6'd4);
    endfunction

    // the bit of a container sent at serial index idx
    function automatic logic pick_bit(input logic [SAMPLE_W-1:0] w,
                                      input logic [5:0] idx,
                                      input logic [5:0] cb,
                                      input logic lsb);
        logic [5:0] k;
        k = lsb ? idx : (cb - 6'd1 - idx);
        return w[k[4:0]];
    endfunction

endpackage

// File: rtl/sai_tx_bclk.sv
module sai_tx_bclk (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic strobe,
    input  logic fall_launch,
    output logic bclk,
    output logic launch
);

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            bclk <= 1'b0;
        end else if (strobe) begin
            bclk <= ~bclk;
        end
    end

    // bclk low now means this strobe makes a rising edge
    assign launch = enable && strobe && (bclk == fall_launch);

endmodule

// File: rtl/sai_tx_packer.sv
module sai_tx_packer
    import sai_tx_pkg::*;
(
    input  logic [SAMPLE_W-1:0] raw,
    input  logic [2:0]          size_code,
    input  logic [2:0]          mask_bits,
    output logic [SAMPLE_W-1:0] word,
    output logic [5:0]          cbits
);

    logic [5:0]  valid_w;
    logic [63:0] keep;

    always_comb begin
        cbits   = slot_bits(size_code);
        valid_w = cbits - {3'b000, mask_bits};
        keep    = (64'd1 << valid_w) - 64'd1;
        word    = (raw & keep[SAMPLE_W-1:0]) << mask_bits;
    end

endmodule

// File: rtl/sai_tx_seq.sv
module sai_tx_seq
    import sai_tx_pkg::*;
#(
    parameter int CLEN_W = 15,
    parameter int OFF_W  = 11,
    parameter int SYNC_W = 8,
    parameter int SLOT_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    launch,
    input  logic                    pulse_mode,
    input  logic                    left_high,
    input  logic [CLEN_W-1:0]       chan_len_m1,
    input  logic                    odd_frame,
    input  logic [OFF_W-1:0]        data_off,
    input  logic [SYNC_W-1:0]       sync_len_m1,
    input  logic [SLOT_W-1:0]       slots_m1,
    input  logic [(1<<SLOT_W)-1:0]  slot_mask,
    input  logic                    lsb_first,
    input  logic [SAMPLE_W-1:0]     new_word,
    input  logic [5:0]              cbits,
    input  logic                    in_valid,
    output logic                    in_ready,
    output logic                    sd,
    output logic                    fs,
    output logic                    uflow
);

    localparam int POS_W = CLEN_W + 2;

    seq_state_e           state, nstate;
    logic [POS_W-1:0]     pos, np, half_len, frame_last, half2_at, off_ext;
    logic [5:0]           bit_i;
    logic [SLOT_W-1:0]    slot, start_slot;
    logic [SAMPLE_W-1:0]  word, load_word;
    logic                 at_off, at_half2, wrap, slot_last, cont, more;
    logic                 start, take, sd_n, fs_n;

    assign off_ext    = POS_W'(data_off);
    assign half_len   = POS_W'(chan_len_m1) + POS_W'(1);
    assign frame_last = {half_len[POS_W-2:0], 1'b0} + POS_W'(odd_frame) - POS_W'(1);
    assign half2_at   = half_len + off_ext;
    assign np         = (state == ST_IDLE || pos == frame_last) ? '0 : pos + POS_W'(1);
    assign wrap       = (np == '0);
    assign at_off     = (np == off_ext);
    assign at_half2   = !pulse_mode && (np == half2_at);
    assign slot_last  = (bit_i == cbits - 6'd1);
    assign cont       = (state == ST_DATA) && !slot_last;
    assign more       = pulse_mode && (state == ST_DATA) && slot_last && (slot != slots_m1);

    // slot start events at the position about to be emitted
    always_comb begin
        start      = 1'b0;
        start_slot = '0;
        if (at_off) begin
            start = 1'b1;
        end else if (at_half2) begin
            start      = 1'b1;
            start_slot = SLOT_W'(1);
        end else if (!wrap && more) begin
            start      = 1'b1;
            start_slot = slot + SLOT_W'(1);
        end
    end

    always_comb begin
        nstate = state;
        if (!enable) begin
            nstate = ST_IDLE;
        end else if (launch) begin
            unique case (state)
                ST_IDLE, ST_LEAD, ST_TAIL:
                    nstate = start ? ST_DATA : (wrap ? ST_LEAD : state);
                ST_DATA: begin
                    if (start)     nstate = ST_DATA;
                    else if (wrap) nstate = ST_LEAD;
                    else if (cont) nstate = ST_DATA;
                    else           nstate = ST_TAIL;
                end
                default: nstate = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    assign take      = launch && start && slot_mask[start_slot];
    assign in_ready  = take;
    assign load_word = (take && in_valid) ? new_word : '0;

    always_comb begin
        if (start)
            sd_n = pick_bit(load_word, 6'd0, cbits, lsb_first);
        else if (cont && !wrap)
            sd_n = pick_bit(word, bit_i + 6'd1, cbits, lsb_first);
        else
            sd_n = 1'b0;
        if (pulse_mode) fs_n = (np <= POS_W'(sync_len_m1));
        else            fs_n = (np >= half_len) ^ left_high;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            pos   <= '0;
            bit_i <= '0;
            slot  <= '0;
            word  <= '0;
            sd    <= 1'b0;
            fs    <= 1'b0;
            uflow <= 1'b0;
        end else begin
            uflow <= take && !in_valid;
            if (launch) begin
                pos <= np;
                sd  <= sd_n;
                fs  <= fs_n;
                if (start) begin
                    bit_i <= '0;
                    slot  <= start_slot;
                    word  <= load_word;
                end else if (cont) begin
                    bit_i <= bit_i + 6'd1;
                end
            end
        end
    end

endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
    import sai_tx_pkg::*;
#(
    parameter int CLEN_W = 15,
    parameter int OFF_W  = 11,
    parameter int SYNC_W = 8,
    parameter int SLOT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tx_en,
    input  logic                   bclk_en,
    input  logic                   pulse_mode,
    input  logic                   left_high,
    input  logic [CLEN_W-1:0]      chan_len_m1,
    input  logic                   odd_frame,
    input  logic [OFF_W-1:0]       data_off,
    input  logic [SYNC_W-1:0]      sync_len_m1,
    input  logic [2:0]             size_code,
    input  logic [2:0]             mask_bits,
    input  logic                   lsb_first,
    input  logic                   fall_launch,
    input  logic [SLOT_W-1:0]      slots_m1,
    input  logic [(1<<SLOT_W)-1:0] slot_mask,
    input  logic                   s_valid,
    input  logic [SAMPLE_W-1:0]    s_data,
    output logic                   s_ready,
    output logic                   bclk,
    output logic                   fclk,
    output logic                   sdata,
    output logic                   underflow
);

    logic                launch;
    logic [SAMPLE_W-1:0] packed_word;
    logic [5:0]          cbits;

    sai_tx_bclk u_bclk (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (tx_en),
        .strobe      (bclk_en),
        .fall_launch (fall_launch),
        .bclk        (bclk),
        .launch      (launch)
    );

    sai_tx_packer u_pack (
        .raw       (s_data),
        .size_code (size_code),
        .mask_bits (mask_bits),
        .word      (packed_word),
        .cbits     (cbits)
    );

    sai_tx_seq #(
        .CLEN_W (CLEN_W),
        .OFF_W  (OFF_W),
        .SYNC_W (SYNC_W),
        .SLOT_W (SLOT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (tx_en),
        .launch      (launch),
        .pulse_mode  (pulse_mode),
        .left_high   (left_high),
        .chan_len_m1 (chan_len_m1),
        .odd_frame   (odd_frame),
        .data_off    (data_off),
        .sync_len_m1 (sync_len_m1),
        .slots_m1    (slots_m1),
        .slot_mask   (slot_mask),
        .lsb_first   (lsb_first),
        .new_word    (packed_word),
        .cbits       (cbits),
        .in_valid    (s_valid),
        .in_ready    (s_ready),
        .sd          (sdata),
        .fs          (fclk),
        .uflow       (underflow)
    );

endmodule

// File: rtl/serial_tx_framer_chk.sv
module serial_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic bclk_en,
    input logic s_valid,
    input logic s_ready,
    input logic bclk,
    input logic fclk,
    input logic sdata,
    input logic underflow
);

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!bclk && !sdata && !fclk && !underflow)); // R10

    AST_READY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (tx_en && bclk_en)); // R11

    AST_BCLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && bclk_en) |=> (bclk != $past(bclk))); // R1

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !bclk_en) |=> ($stable(bclk) && $stable(sdata) && $stable(fclk))); // R2

    AST_UF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> !underflow); // R9

    AST_UF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> $past(!s_valid)); // R9

endmodule

bind serial_tx_framer serial_tx_framer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .bclk_en   (bclk_en),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .bclk      (bclk),
    .fclk      (fclk),
    .sdata     (sdata),
    .underflow (underflow)
);

// File: tb/serial_tx_framer_tb_top.sv
module serial_tx_framer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_en, bclk_en, pulse_mode, left_high, odd_frame;
    logic [14:0] chan_len_m1;
    logic [10:0] data_off;
    logic [7:0]  sync_len_m1;
    logic [2:0]  size_code, mask_bits, slots_m1;
    logic        lsb_first, fall_launch;
    logic [7:0]  slot_mask;
    logic        s_valid;
    logic [31:0] s_data;
    logic        s_ready, bclk, fclk, sdata, underflow;

    int vec_cnt = 0;
    int err_cnt = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_tx_framer dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bclk_en(bclk_en),
        .pulse_mode(pulse_mode), .left_high(left_high), .chan_len_m1(chan_len_m1),
        .odd_frame(odd_frame), .data_off(data_off), .sync_len_m1(sync_len_m1),
        .size_code(size_code), .mask_bits(mask_bits), .lsb_first(lsb_first),
        .fall_launch(fall_launch), .slots_m1(slots_m1), .slot_mask(slot_mask),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .bclk(bclk),
        .fclk(fclk), .sdata(sdata), .underflow(underflow)
    );

    // model state
    int          ph, n, samp_k;
    logic        exp_sd, exp_fc, exp_bclk, exp_uf;
    logic [31:0] mword;
    string       sd_req;

    function automatic logic [31:0] sample_of(int k);
        return (k * 32'h9E3779B9) ^ 32'h5A5A1234;
    endfunction

    function automatic int cont_len(int code);
        return (code == 0) ? 8 : 4 * code + 4;
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        vec_cnt++;
        if (act !== exp) begin
            err_cnt++;
            $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic run_cfg(int cycles, int sp, int vmode);
        int F, L, C, p, k, idx, W;
        bit insl, launch, er, rdy_seen, vld;
        logic [63:0] keep;
        L  = int'(chan_len_m1) + 1;
        F  = 2 * L + int'(odd_frame);
        C  = cont_len(int'(size_code));
        ph = 0; n = 0;
        exp_sd = 0; exp_fc = 0; exp_bclk = 0; exp_uf = 0; mword = '0; sd_req = "R5";
        for (int c = 0; c < cycles + 6; c++) begin
            bit en_now;
            en_now = (c < cycles);
            chk("R1", "bclk", bclk, exp_bclk);
            chk(pulse_mode ? "R4" : "R3", "fclk", fclk, exp_fc);
            chk(sd_req, "sdata", sdata, exp_sd);
            chk("R9", "underflow", underflow, exp_uf);
            tx_en   = en_now;
            bclk_en = ((c % sp) == 0);
            vld     = (vmode == 0) ? 1'b1 : (vmode == 1) ? ((c % 4) != 1) : 1'b0;
            s_valid = vld;
            s_data  = sample_of(samp_k);
            #1;
            er = 0;
            exp_uf = 0;
            if (!en_now) begin
                ph = 0; n = 0;
                exp_sd = 0; exp_fc = 0; exp_bclk = 0;
                sd_req = "R10";
                chk("R10", "s_ready while disabled", s_ready, 1'b0);
            end else begin
                launch = bclk_en && (ph == int'(fall_launch));
                if (launch) begin
                    p = n % F;
                    insl = 0; k = 0; idx = 0;
                    if (!pulse_mode) begin
                        if (p >= L + int'(data_off) && p - (L + int'(data_off)) < C) begin
                            insl = 1; k = 1; idx = p - (L + int'(data_off));
                        end else if (p >= int'(data_off) && p - int'(data_off) < C) begin
                            insl = 1; k = 0; idx = p - int'(data_off);
                        end
                        exp_fc = ((p >= L) ? 1'b1 : 1'b0) ^ left_high;
                    end else begin
                        if (p >= int'(data_off) && (p - int'(data_off)) / C <= int'(slots_m1)) begin
                            insl = 1; k = (p - int'(data_off)) / C; idx = (p - int'(data_off)) % C;
                        end
                        exp_fc = (p <= int'(sync_len_m1));
                    end
                    if (insl && idx == 0) begin
                        if (slot_mask[k]) begin
                            er = 1;
                            W = C - int'(mask_bits);
                            keep = (64'd1 << W) - 64'd1;
                            mword = vld ? ((s_data & keep[31:0]) << mask_bits) : 32'd0;
                            exp_uf = !vld;
                        end else begin
                            mword = '0;
                        end
                    end
                    exp_sd = insl ? (lsb_first ? mword[idx] : mword[C - 1 - idx]) : 1'b0;
                    if (insl && !slot_mask[k])  sd_req = "R8";
                    else if (lsb_first)         sd_req = "R7";
                    else if (mask_bits != 0)    sd_req = "R6";
                    else if (fall_launch)       sd_req = "R2";
                    else                        sd_req = "R5";
                    n++;
                end
                chk("R11", "s_ready", s_ready, er);
                if (bclk_en) ph ^= 1;
                exp_bclk = ph[0];
            end
            rdy_seen = s_ready;
            @(posedge clk);
            if (rdy_seen && vld) samp_k++;
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 0; tx_en = 0; bclk_en = 0; pulse_mode = 0; left_high = 0; odd_frame = 0;
        chan_len_m1 = 15; data_off = 1; sync_len_m1 = 0; size_code = 3; mask_bits = 0;
        lsb_first = 0; fall_launch = 0; slots_m1 = 1; slot_mask = 8'hFF;
        s_valid = 0; s_data = 0; samp_k = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state, R10
        chk("R10", "reset bclk", bclk, 1'b0);
        chk("R10", "reset sdata", sdata, 1'b0);
        chk("R10", "reset fclk", fclk, 1'b0);
        chk("R10", "reset underflow", underflow, 1'b0);
        rst_n = 1;
        @(negedge clk);
        for (int i = 0; i < 96; i++) begin
            int C, sp, vmode, F;
            pulse_mode  = (i % 2) == 1;
            left_high   = (i / 2) % 2;
            odd_frame   = (i / 4) % 2;
            lsb_first   = (i / 8) % 2;
            fall_launch = (i / 3) % 2;
            size_code   = 3'(1 + i % 7);
            mask_bits   = 3'(((i / 7) % 4) * 2);
            data_off    = 11'(i % 3);
            C           = cont_len(int'(size_code));
            if (!pulse_mode) begin
                // level frames, some with slot 0 cut short by slot 1
                chan_len_m1 = 15'(15 + (i % 3) * 4);
                slot_mask   = (i % 5 == 0) ? 8'h02 : (i % 5 == 1) ? 8'h01 : 8'hFF;
                slots_m1    = 3'(i % 8);
                sync_len_m1 = 0;
            end else begin
                // TDM frames with up to eight slots
                slots_m1    = 3'((i / 2) % 8);
                chan_len_m1 = 15'(((int'(slots_m1) + 1) * C + (i % 3)) / 2 + (i % 4));
                sync_len_m1 = 8'(i % 4);
                slot_mask   = 8'hFF ^ 8'(i * 37);
            end
            sp    = 1 + (i % 3);
            vmode = (i / 5) % 3;
            F     = 2 * (int'(chan_len_m1) + 1) + int'(odd_frame);
            run_cfg(2 * F * 2 * sp + 4, sp, vmode);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            err_cnt++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
            $finish;
        end
    end

endmodule